// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt requests from four internal event strobes (an interval tick, a serial-transfer tick and two timer ticks) and from five external pins, holds each one in a request flag, and decides every clock cycle whether one of them should be handed to the processor. When a request is taken, the block clears its flag, raises a vector-valid pulse with the vector table address of the winning source, and counts one level deeper in a 2-bit service-level field. A return strobe from the processor steps the level back down.

Seven of the sources can vector. Each has its own enable bit, and one master enable gates them all. When several normal requests wait together, a fixed order decides which one goes first. A selector input can lift one source above the rest. That source then wins at level 0, and it can also interrupt a level-1 service to give one extra nesting level. Two more pins are edge-detected test inputs. They only set flags that software polls and clears, and they never produce a vector. A wake output tells standby logic that some enabled request is pending, whether or not the master enable is set.

Top module: `irqVectorCtrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all nine request flags are 0, the service level is 0, and vecValid and wakeReq are 0.
- R2: Flag bit positions are: interval 0, pin A 1, pin B 2, pin C 3, serial 4, timer0 5, timer1 6, test pin 2 at 7, test pin 3 at 8. A high tick input sets its flag at that clock edge. Pin A sets its flag on either edge and pin C on a rising edge, each at the first clock edge that samples the new level.
- R3: Pin B uses the 2-bit mode input int0Mode: 00 is rising edge, 01 is falling edge, 10 is both edges and 11 is disabled. In mode 11 no edge sets flag 2.
- R4: Test pin 2 sets flag 7 on a rising edge and test pin 3 sets flag 8 on a falling edge. testClr bit 0 clears flag 7 and bit 1 clears flag 8. These flags never cause vecValid. If a set and a clear hit a flag in the same cycle, the set wins.
- R5: A source is accepted only when its flag is set, its enableMask bit is 1, masterEn is 1 and retStrobe is 0 in that cycle.
- R6: At level 0 with no raised source pending, the lowest pending enabled bit index wins, so the order is interval, pin A, pin B, pin C, serial, timer0, timer1.
- R7: hiSel values 0 to 6 select the raised source and 7 selects none. A pending enabled raised source wins over all others at level 0.
- R8: At level 1 only the raised source can be accepted. At level 2 nothing is accepted. The level never reaches 3.
- R9: On acceptance, the edge that follows clears the winner's flag, raises level by 1, pulses vecValid for one cycle and drives vecAddr with twice the source index. A new set arriving in the same cycle keeps the flag at 1.
- R10: retStrobe lowers the level by 1 at the next edge when the level is nonzero. At level 0 it has no effect.
- R11: wakeReq is 1 exactly when some flag among bits 0 to 6 is set together with its enableMask bit, whatever masterEn is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickBt | input | 1 | Interval event strobe |
| tickSer | input | 1 | Serial transfer strobe |
| tickT0 | input | 1 | Timer 0 strobe |
| tickT1 | input | 1 | Timer 1 strobe |
| pinA | input | 1 | External pin, both-edge request |
| pinB | input | 1 | External pin, mode-selected edge |
| pinC | input | 1 | External pin, rising-edge request |
| testPin2 | input | 1 | Test input, rising edge sets flag 7 |
| testPin3 | input | 1 | Test input, falling edge sets flag 8 |
| int0Mode | input | 2 | Edge mode of pinB |
| testClr | input | 2 | Clear strobes for flags 7 and 8 |
| enableMask | input | 7 | Per-source enable bits, indexed like flags 0 to 6 |
| masterEn | input | 1 | Master enable |
| hiSel | input | 3 | Raised source index, 7 for none |
| retStrobe | input | 1 | Return-from-service strobe |
| reqFlags | output | 9 | Request flags |
| status | output | 2 | Current service level |
| vecValid | output | 1 | One-cycle acceptance pulse |
| vecAddr | output | 4 | Vector table address of accepted source |
| wakeReq | output | 1 | Standby release request |

## Verification
The directed part uses several simultaneous requests with no raised source, which separates the fixed order from any other tie-break. It then lifts a late source to level 1 and shows that the raised source preempts only from that level, and that level 2 blocks everything. Test pin edges and pinB in its disabled mode show flags that do or do not set without ever vectoring. With the master enable off, wakeReq must still follow the enabled flags, which tells the wake path apart from acceptance. Random stimulus then toggles pins, ticks, masks, selector and return strobe together, so that set and clear collisions, a return in the same cycle as a pending request, and changes of mode are all compared against a bench model.

// File: rtl/irqPkg.sv
package irqPkg;
  parameter int NUM_VEC  = 7;
  parameter int NUM_TEST = 2;
  parameter int NUM_FLAG = NUM_VEC + NUM_TEST;
  parameter int NUM_PIN  = 5;
  parameter int IDX_W    = $clog2(NUM_VEC + 1);
  parameter int VEC_W    = IDX_W + 1;
  parameter int STAT_W   = 2;

  // Edge mode encoding shared by all edge detectors
  parameter logic [1:0] EDGE_RISE = 2'b00;
  parameter logic [1:0] EDGE_FALL = 2'b01;
  parameter logic [1:0] EDGE_BOTH = 2'b10;
  parameter logic [1:0] EDGE_OFF  = 2'b11;

  typedef struct packed {
    logic              accept;
    logic [IDX_W-1:0]  idx;
    logic              statusUp;
    logic              statusDown;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqEdgeDet.sv
module irqEdgeDet (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       edgeHit
);
  import irqPkg::*;

  logic prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= pin;
  end

  always_comb begin
    unique case (mode)
      EDGE_RISE: edgeHit = pin & ~prevLevel;
      EDGE_FALL: edgeHit = ~pin & prevLevel;
      EDGE_BOTH: edgeHit = pin ^ prevLevel;
      default:   edgeHit = 1'b0;
    endcase
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PIN-1:0]  pins,
  input  logic                tickBt,
  input  logic                tickSer,
  input  logic                tickT0,
  input  logic                tickT1,
  input  logic [1:0]          int0Mode,
  input  logic [NUM_TEST-1:0] testClr,
  input  ctrlStrobes_t        strobes,
  output logic [NUM_FLAG-1:0] reqFlags,
  output logic [STAT_W-1:0]   status,
  output logic                vecValid,
  output logic [VEC_W-1:0]    vecAddr
);
  // pin order: 0 = A (both), 1 = B (programmable), 2 = C (rise),
  //            3 = test 2 (rise), 4 = test 3 (fall)
  logic [NUM_PIN-1:0]  pinHit;
  logic [NUM_FLAG-1:0] setMask;
  logic [NUM_FLAG-1:0] clrMask;

  function automatic logic [1:0] fixedMode(input int p);
    case (p)
      0:       return EDGE_BOTH;
      2:       return EDGE_RISE;
      3:       return EDGE_RISE;
      4:       return EDGE_FALL;
      default: return EDGE_OFF;
    endcase
  endfunction

  for (genvar gp = 0; gp < NUM_PIN; gp++) begin : gEdge
    logic [1:0] pinMode;
    if (gp == 1) begin : gProg
      assign pinMode = int0Mode;
    end else begin : gFixed
      assign pinMode = fixedMode(gp);
    end
    irqEdgeDet uEdge (
      .clk     (clk),
      .rstN    (rstN),
      .pin     (pins[gp]),
      .mode    (pinMode),
      .edgeHit (pinHit[gp])
    );
  end

  always_comb begin
    setMask    = '0;
    setMask[0] = tickBt;
    setMask[1] = pinHit[0];
    setMask[2] = pinHit[1];
    setMask[3] = pinHit[2];
    setMask[4] = tickSer;
    setMask[5] = tickT0;
    setMask[6] = tickT1;
    setMask[NUM_VEC]   = pinHit[3];
    setMask[NUM_VEC+1] = pinHit[4];
  end

  for (genvar gf = 0; gf < NUM_FLAG; gf++) begin : gClr
    if (gf < NUM_VEC) begin : gVecClr
      assign clrMask[gf] = strobes.accept && (strobes.idx == IDX_W'(gf));
    end else begin : gTestClr
      assign clrMask[gf] = testClr[gf-NUM_VEC];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqFlags <= '0;
    else       reqFlags <= (reqFlags & ~clrMask) | setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
    end else if (strobes.statusDown) begin
      status <= status - 1'b1;
    end else if (strobes.statusUp) begin
      status <= status + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecAddr  <= '0;
    end else begin
      vecValid <= strobes.accept;
      if (strobes.accept) vecAddr <= {strobes.idx, 1'b0};
    end
  end
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic [NUM_VEC-1:0] vecFlags,
  input  logic [STAT_W-1:0]  status,
  input  logic [NUM_VEC-1:0] enableMask,
  input  logic               masterEn,
  input  logic [IDX_W-1:0]   hiSel,
  input  logic               retStrobe,
  output ctrlStrobes_t       strobes,
  output logic               wakeReq
);
  logic [NUM_VEC-1:0] pendEn;
  logic               anyPend;
  logic [IDX_W-1:0]   lowIdx;
  logic               hiValid;
  logic               hiPend;
  logic               takeLow;
  logic               takeHi;

  assign pendEn  = vecFlags & enableMask;
  assign anyPend = |pendEn;
  assign wakeReq = anyPend;

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pendEn[i]) lowIdx = IDX_W'(i);
    end
  end

  assign hiValid = (hiSel < IDX_W'(NUM_VEC));
  assign hiPend  = hiValid && pendEn[hiSel];

  always_comb begin
    takeLow = 1'b0;
    takeHi  = 1'b0;
    if (masterEn && !retStrobe) begin
      if (status == 2'd0) begin
        takeHi  = hiPend;
        takeLow = anyPend && !hiPend;
      end else if (status == 2'd1) begin
        takeHi  = hiPend;
      end
    end
  end

  always_comb begin
    strobes.accept     = takeLow || takeHi;
    strobes.idx        = takeHi ? hiSel : lowIdx;
    strobes.statusUp   = takeLow || takeHi;
    strobes.statusDown = retStrobe && (status != '0);
  end
endmodule

// File: rtl/irqVectorCtrl.sv
module irqVectorCtrl
  import irqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickBt,
  input  logic                tickSer,
  input  logic                tickT0,
  input  logic                tickT1,
  input  logic                pinA,
  input  logic                pinB,
  input  logic                pinC,
  input  logic                testPin2,
  input  logic                testPin3,
  input  logic [1:0]          int0Mode,
  input  logic [NUM_TEST-1:0] testClr,
  input  logic [NUM_VEC-1:0]  enableMask,
  input  logic                masterEn,
  input  logic [IDX_W-1:0]    hiSel,
  input  logic                retStrobe,
  output logic [NUM_FLAG-1:0] reqFlags,
  output logic [STAT_W-1:0]   status,
  output logic                vecValid,
  output logic [VEC_W-1:0]    vecAddr,
  output logic                wakeReq
);
  ctrlStrobes_t strobes;

  irqDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .pins     ({testPin3, testPin2, pinC, pinB, pinA}),
    .tickBt   (tickBt),
    .tickSer  (tickSer),
    .tickT0   (tickT0),
    .tickT1   (tickT1),
    .int0Mode (int0Mode),
    .testClr  (testClr),
    .strobes  (strobes),
    .reqFlags (reqFlags),
    .status   (status),
    .vecValid (vecValid),
    .vecAddr  (vecAddr)
  );

  irqControl uCtl (
    .vecFlags   (reqFlags[NUM_VEC-1:0]),
    .status     (status),
    .enableMask (enableMask),
    .masterEn   (masterEn),
    .hiSel      (hiSel),
    .retStrobe  (retStrobe),
    .strobes    (strobes),
    .wakeReq    (wakeReq)
  );
endmodule

// File: rtl/irqVectorChk.sv
module irqVectorChk
  import irqPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              masterEn,
  input logic              retStrobe,
  input logic              vecValid,
  input logic [VEC_W-1:0]  vecAddr,
  input logic [STAT_W-1:0] status
);
  assert_level_up_R9: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> status == $past(status) + 2'd1);

  assert_vec_even_R9: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (!vecAddr[0] && vecAddr < VEC_W'(2 * NUM_VEC)));

  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(masterEn) |-> !vecValid);

  assert_level2_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(status) == 2'd2) |-> !vecValid);

  assert_no_level3_R8: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'd3);

  assert_return_down_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(retStrobe) && $past(status) != 2'd0) |-> status == $past(status) - 2'd1);
endmodule

bind irqVectorCtrl irqVectorChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .masterEn  (masterEn),
  .retStrobe (retStrobe),
  .vecValid  (vecValid),
  .vecAddr   (vecAddr),
  .status    (status)
);

// File: tb/sim_irqVectorCtrl.sv
`timescale 1ns/1ps
module sim_irqVectorCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickBt = 0, tickSer = 0, tickT0 = 0, tickT1 = 0;
  logic pinA = 0, pinB = 0, pinC = 0, testPin2 = 0, testPin3 = 0;
  logic [1:0] int0Mode = 2'b00;
  logic [1:0] testClr = 2'b00;
  logic [6:0] enableMask = '0;
  logic masterEn = 0;
  logic [2:0] hiSel = 3'd7;
  logic retStrobe = 0;
  logic [8:0] reqFlags;
  logic [1:0] status;
  logic vecValid;
  logic [3:0] vecAddr;
  logic wakeReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  logic [8:0] mFlags = '0;
  logic [1:0] mStatus = '0;
  logic       mVecValid = 0;
  logic [3:0] mVecAddr = '0;
  logic [4:0] mPrev = '0;

  always #4 clk = ~clk;

  irqVectorCtrl u0 (
    .clk(clk), .rstN(rstN), .tickBt(tickBt), .tickSer(tickSer),
    .tickT0(tickT0), .tickT1(tickT1), .pinA(pinA), .pinB(pinB), .pinC(pinC),
    .testPin2(testPin2), .testPin3(testPin3), .int0Mode(int0Mode),
    .testClr(testClr), .enableMask(enableMask), .masterEn(masterEn),
    .hiSel(hiSel), .retStrobe(retStrobe), .reqFlags(reqFlags),
    .status(status), .vecValid(vecValid), .vecAddr(vecAddr), .wakeReq(wakeReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowestSet(input logic [6:0] v);
    for (int i = 0; i < 7; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic edgeOf(input logic now, input logic prev, input logic [1:0] md);
    case (md)
      2'b00: return now & ~prev;
      2'b01: return ~now & prev;
      2'b10: return now ^ prev;
      default: return 1'b0;
    endcase
  endfunction

  // compute next model state from current inputs, advance one cycle, compare
  task automatic step();
    logic [6:0] pend;
    logic       acc;
    int         idx;
    logic       hiOk;
    logic [8:0] setM, clrM;
    logic [4:0] now;
    now  = {testPin3, testPin2, pinC, pinB, pinA};
    pend = mFlags[6:0] & enableMask;
    acc  = 0; idx = 0;
    hiOk = (hiSel < 3'd7) && pend[hiSel];
    if (masterEn && !retStrobe) begin
      if (mStatus == 2'd0 && pend != 0) begin
        acc = 1; idx = hiOk ? int'(hiSel) : lowestSet(pend);
      end else if (mStatus == 2'd1 && hiOk) begin
        acc = 1; idx = int'(hiSel);
      end
    end
    setM = {edgeOf(now[4], mPrev[4], 2'b01), edgeOf(now[3], mPrev[3], 2'b00),
            tickT1, tickT0, tickSer,
            edgeOf(now[2], mPrev[2], 2'b00), edgeOf(now[1], mPrev[1], int0Mode),
            edgeOf(now[0], mPrev[0], 2'b10), tickBt};
    clrM = {testClr, 7'b0};
    if (acc) clrM[idx] = 1'b1;
    mFlags = (mFlags & ~clrM) | setM;
    if (retStrobe && mStatus != 0) mStatus = mStatus - 1;
    else if (acc) mStatus = mStatus + 1;
    mVecValid = acc;
    if (acc) mVecAddr = 4'(2 * idx);
    mPrev = now;
    @(negedge clk);
    check("R2 R3 R4 flags", int'(reqFlags), int'(mFlags));
    check("R8 R10 status", int'(status), int'(mStatus));
    check("R5 R6 R7 vecValid", int'(vecValid), int'(mVecValid));
    if (mVecValid) check("R9 vecAddr", int'(vecAddr), int'(mVecAddr));
    check("R11 wakeReq", int'(wakeReq), int'(|(mFlags[6:0] & enableMask)));
  endtask

  task automatic quiet();
    tickBt = 0; tickSer = 0; tickT0 = 0; tickT1 = 0;
    testClr = 0; retStrobe = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", int'(reqFlags), 0);
    check("R1 status in reset", int'(status), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 flags after reset", int'(reqFlags), 0);
    check("R1 status after reset", int'(status), 0);
    check("R1 vecValid after reset", int'(vecValid), 0);
    check("R1 wakeReq after reset", int'(wakeReq), 0);

    // R6: fixed order among simultaneous requests, no raised source
    enableMask = 7'h7F; masterEn = 1; hiSel = 3'd7;
    tickT1 = 1; tickSer = 1; pinC = 1;
    step(); quiet();
    check("R2 three flags set", int'(reqFlags), 9'h058);
    step();
    check("R6 lowest index wins", int'(vecAddr), 6);
    check("R9 level raised", int'(status), 1);
    // R8: at level 1 normal requests wait
    step();
    check("R8 no normal preempt", int'(vecValid), 0);
    // R7: raise timer1, it preempts from level 1
    hiSel = 3'd6;
    step();
    check("R7 raised source preempts", int'(vecAddr), 12);
    check("R8 level 2 reached", int'(status), 2);
    tickBt = 1; step(); quiet(); step();
    check("R8 level 2 blocks all", int'(vecValid), 0);
    // R10: return twice, then serial wins at level 0 after interval
    retStrobe = 1; step(); step(); quiet();
    check("R10 back to level 0", int'(status), 0);
    retStrobe = 1; step(); quiet();
    check("R10 return at level 0 ignored", int'(status), 0);
    step(); step(); // accepts interval
    retStrobe = 1; step(); step(); quiet();

    // R4: test pins set flags, never vector
    testPin2 = 1; step(); testPin3 = 1; step(); testPin3 = 0; step();
    check("R4 test flags set", int'(reqFlags[8:7]), 3);
    step();
    check("R4 test flags never vector", int'(reqFlags[8:7]), 3);
    testClr = 2'b11; step(); quiet();
    check("R4 test flags cleared", int'(reqFlags[8:7]), 0);

    // R3: disabled mode ignores pinB edges
    masterEn = 0; int0Mode = 2'b11;
    pinB = 1; step(); pinB = 0; step();
    check("R3 mode 11 ignored", int'(reqFlags[2]), 0);
    int0Mode = 2'b01; pinB = 1; step(); pinB = 0; step();
    check("R3 falling mode sets flag", int'(reqFlags[2]), 1);
    // R11: wake with master off
    check("R11 wake while master off", int'(wakeReq), 1);
    enableMask = 7'h7B; step();
    check("R11 wake follows enable", int'(wakeReq), int'(|(reqFlags[6:0] & 7'h7B)));

    // random phase
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      tickBt  = (r[3:0] == 0);
      tickSer = (r[7:4] == 0);
      tickT0  = (r[11:8] == 0);
      tickT1  = (r[15:12] == 0);
      if (r[18:16] == 0) pinA = ~pinA;
      if (r[21:19] == 0) pinB = ~pinB;
      if (r[24:22] == 0) pinC = ~pinC;
      if (r[26:25] == 0) testPin2 = ~testPin2;
      if (r[28:27] == 0) testPin3 = ~testPin3;
      r = $urandom;
      if (r[4:0] == 0) int0Mode = r[6:5];
      testClr   = (r[10:7] == 0) ? r[12:11] : 2'b00;
      retStrobe = (r[14:13] == 0);
      if (r[18:15] == 0) enableMask = r[25:19];
      masterEn  = (r[27:26] != 0);
      if (r[31:28] == 0) hiSel = 3'($urandom_range(0, 7));
      step();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule